// File: doc/BRIEF.md
# Microcoded Operate Instruction Unit

This block carries out the operate class of instructions for a 12-bit accumulator machine. It holds a one-bit link and a 12-bit accumulator. When the instruction strobe is high with an operate word present, the block updates both registers on that clock edge. The word may ask for several micro-operations at once, and the block applies them in a fixed order inside a single step. In the same cycle it raises combinational skip and halt pulses for the sequencer around it.

Two groups of operations are handled. The first group covers clear, complement and increment of the link and accumulator, and rotates and a half-swap of the accumulator. The second group covers conditional skips on the accumulator sign, on a zero accumulator and on the link. It also covers an accumulator clear, an OR of the front-panel switches into the accumulator, and halt. Words of other opcodes, and operate words of the third group, leave the block alone. Because each group can clear and then build a value, a program drives the held state through the strobe alone. An example is clear followed by an OR of the switches.

Top module: `opr_unit`

## Requirements
- R1: While reset is held, link and accumulator are 0, and skip and halt are low.
- R2: With the strobe low, or with bits 11:9 not 111, or with bits 11:9 = 111, bit 8 = 1 and bit 0 = 1, link and accumulator keep their values and skip and halt stay low.
- R3: In group 1 (bits 11:9 = 111, bit 8 = 0), clear AC (bit 7) and clear link (bit 6) act first. Complement AC (bit 5) and complement link (bit 4) then act on the cleared values.
- R4: Group 1 bit 0 then adds one to the 13-bit link:AC value, so a carry out of the accumulator inverts the link.
- R5: Rotate code bits 3:1 acts last on link:AC, with link above bit 11. Code 100 rotates right by one, 010 rotates left by one, 101 rotates right by two, and 011 rotates left by two.
- R6: Rotate code 001 exchanges AC bits 11:6 with bits 5:0 and leaves the link unchanged. Codes 110 and 111 do no rotate.
- R7: In group 2 (bits 11:9 = 111, bit 8 = 1, bit 0 = 0) with bit 3 = 0, skip is high if any selected condition holds. The conditions are bit 6 (AC bit 11 set), bit 5 (AC equal to 0) and bit 4 (link set).
- R8: In group 2 with bit 3 = 1, skip is high only if every selected condition is false. With none of bits 6:4 set, this gives an unconditional skip.
- R9: The group 2 skip test uses the accumulator as it was before group 2 bit 7 clears it. After that clear, bit 2 ORs the switches into the accumulator. Group 2 never changes the link.
- R10: Halt is high only in a strobed group 2 cycle with bit 1 set. A group 1 word never raises skip or halt.
- R11: Operate words 7000 and 7400 (octal), which have no function bits set, leave link and accumulator unchanged and raise neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe, one cycle per instruction |
| instr | input | 12 | Instruction word |
| switches | input | 12 | Front-panel switch values |
| link | output | 1 | Link register |
| acc | output | 12 | Accumulator register |
| skip | output | 1 | Skip pulse during the strobe cycle |
| halt | output | 1 | Halt pulse during the strobe cycle |

## Verification
Each single group 1 bit is run alone against known values loaded through a group 2 clear-and-switch word. This separates the order of clears from the order of complements, and an increment that wraps through all ones shows the carry into the link. Every rotate code is applied to a pattern with distinct end bits so that a direction, distance or swap mistake shows up. Each group 2 condition is tried in both senses with the condition true and with it false. A skip-on-zero combined with clear tells a test made before the clear from one made after it. Non-operate words, third-group words and unstrobed words are sent against a nonzero state to show that nothing moves.

// File: rtl/opr_pkg.sv
package opr_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_G1   = 2'd1,
    CLS_G2   = 2'd2
  } opr_class_e;

  typedef enum logic [2:0] {
    ROT_NONE = 3'd0,
    ROT_R1   = 3'd1,
    ROT_L1   = 3'd2,
    ROT_R2   = 3'd3,
    ROT_L2   = 3'd4,
    ROT_SWAP = 3'd5
  } rot_e;

  typedef struct packed {
    logic clr_acc;
    logic clr_lnk;
    logic inv_acc;
    logic inv_lnk;
    logic inc;
    rot_e rot;
  } g1_ctl_t;

  typedef struct packed {
    logic clr_acc;
    logic on_neg;
    logic on_zero;
    logic on_link;
    logic invert;
    logic or_sw;
    logic stop;
  } g2_ctl_t;

  localparam logic [2:0] OPR_OPCODE = 3'b111;

endpackage

// File: rtl/opr_rst_sync.sv
module opr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] instr,
  output opr_class_e        cls,
  output g1_ctl_t           g1,
  output g2_ctl_t           g2
);
  logic [2:0] rot_code;

  always_comb begin
    cls = CLS_NONE;
    if (instr[DATA_W-1 -: 3] == OPR_OPCODE) begin
      if (!instr[8])     cls = CLS_G1;
      else if (!instr[0]) cls = CLS_G2;
    end
  end

  assign rot_code = instr[3:1];

  always_comb begin
    g1.clr_acc = instr[7];
    g1.clr_lnk = instr[6];
    g1.inv_acc = instr[5];
    g1.inv_lnk = instr[4];
    g1.inc     = instr[0];
    unique case (rot_code)
      3'b100:  g1.rot = ROT_R1;
      3'b010:  g1.rot = ROT_L1;
      3'b101:  g1.rot = ROT_R2;
      3'b011:  g1.rot = ROT_L2;
      3'b001:  g1.rot = ROT_SWAP;
      default: g1.rot = ROT_NONE;
    endcase
  end

  always_comb begin
    g2.clr_acc = instr[7];
    g2.on_neg  = instr[6];
    g2.on_zero = instr[5];
    g2.on_link = instr[4];
    g2.invert  = instr[3];
    g2.or_sw   = instr[2];
    g2.stop    = instr[1];
  end
endmodule

// File: rtl/opr_group1.sv
module opr_group1
  import opr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  g1_ctl_t           ctl,
  input  logic              link_in,
  input  logic [DATA_W-1:0] acc_in,
  output logic              link_out,
  output logic [DATA_W-1:0] acc_out
);
  localparam int HALF_W = DATA_W / 2;
  localparam int FULL_W = DATA_W + 1;

  logic              lnk_clr, lnk_inv;
  logic [DATA_W-1:0] acc_clr, acc_inv;
  logic [FULL_W-1:0] word_inc, word_rot;

  always_comb begin
    lnk_clr = ctl.clr_lnk ? 1'b0 : link_in;
    acc_clr = ctl.clr_acc ? '0 : acc_in;
    lnk_inv = lnk_clr ^ ctl.inv_lnk;
    acc_inv = ctl.inv_acc ? ~acc_clr : acc_clr;
    word_inc = {lnk_inv, acc_inv} + {{(FULL_W-1){1'b0}}, ctl.inc};
  end

  always_comb begin
    unique case (ctl.rot)
      ROT_R1:   word_rot = {word_inc[0], word_inc[FULL_W-1:1]};
      ROT_L1:   word_rot = {word_inc[FULL_W-2:0], word_inc[FULL_W-1]};
      ROT_R2:   word_rot = {word_inc[1:0], word_inc[FULL_W-1:2]};
      ROT_L2:   word_rot = {word_inc[FULL_W-3:0], word_inc[FULL_W-1 -: 2]};
      ROT_SWAP: word_rot = {word_inc[FULL_W-1], word_inc[HALF_W-1:0],
                            word_inc[DATA_W-1:HALF_W]};
      default:  word_rot = word_inc;
    endcase
  end

  assign link_out = word_rot[FULL_W-1];
  assign acc_out  = word_rot[DATA_W-1:0];
endmodule

// File: rtl/opr_group2.sv
module opr_group2
  import opr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  g2_ctl_t           ctl,
  input  logic              link_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] sw_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              skip_out,
  output logic              halt_out
);
  logic any_hit;
  logic [DATA_W-1:0] acc_clr;

  always_comb begin
    any_hit = (ctl.on_neg  & acc_in[DATA_W-1])
            | (ctl.on_zero & (acc_in == '0))
            | (ctl.on_link & link_in);
    skip_out = any_hit ^ ctl.invert;
    acc_clr  = ctl.clr_acc ? '0 : acc_in;
    acc_out  = ctl.or_sw ? (acc_clr | sw_in) : acc_clr;
    halt_out = ctl.stop;
  end
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] switches,
  output logic              link,
  output logic [DATA_W-1:0] acc,
  output logic              skip,
  output logic              halt
);
  logic              rst_core_n;
  opr_class_e        cls;
  g1_ctl_t           g1_ctl;
  g2_ctl_t           g2_ctl;
  logic              g1_link;
  logic [DATA_W-1:0] g1_acc, g2_acc;
  logic              g2_skip, g2_halt;
  logic              state_en;
  logic              link_nxt, link_q;
  logic [DATA_W-1:0] acc_nxt, acc_q;

  opr_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  opr_decode #(.DATA_W(DATA_W)) u_dec (
    .instr(instr), .cls(cls), .g1(g1_ctl), .g2(g2_ctl)
  );

  opr_group1 #(.DATA_W(DATA_W)) u_g1 (
    .ctl(g1_ctl), .link_in(link_q), .acc_in(acc_q),
    .link_out(g1_link), .acc_out(g1_acc)
  );

  opr_group2 #(.DATA_W(DATA_W)) u_g2 (
    .ctl(g2_ctl), .link_in(link_q), .acc_in(acc_q), .sw_in(switches),
    .acc_out(g2_acc), .skip_out(g2_skip), .halt_out(g2_halt)
  );

  assign state_en = instr_valid && (cls != CLS_NONE);

  always_comb begin
    link_nxt = link_q;
    acc_nxt  = acc_q;
    if (cls == CLS_G1) begin
      link_nxt = g1_link;
      acc_nxt  = g1_acc;
    end else if (cls == CLS_G2) begin
      acc_nxt  = g2_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      link_q <= 1'b0;
      acc_q  <= '0;
    end else if (state_en) begin
      link_q <= link_nxt;
      acc_q  <= acc_nxt;
    end
  end

  assign link = link_q;
  assign acc  = acc_q;
  assign skip = rst_core_n && instr_valid && (cls == CLS_G2) && g2_skip;
  assign halt = rst_core_n && instr_valid && (cls == CLS_G2) && g2_halt;
endmodule

// File: rtl/opr_unit_checker.sv
module opr_unit_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [DATA_W-1:0] instr,
  input logic [DATA_W-1:0] switches,
  input logic              link,
  input logic [DATA_W-1:0] acc,
  input logic              skip,
  input logic              halt
);
  logic is_opr, is_g1, is_g2;
  assign is_opr = (instr[DATA_W-1 -: 3] == 3'b111);
  assign is_g1  = instr_valid && is_opr && !instr[8];
  assign is_g2  = instr_valid && is_opr && instr[8] && !instr[0];

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_g1 || is_g2) |=> $stable({link, acc}));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!skip && !halt));

  assert_g1_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_g1 |-> (!skip && !halt));

  assert_halt_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_g2 |-> (halt == instr[1]));

  assert_always_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_g2 && instr[6:3] == 4'b0001) |-> skip);

  assert_clear_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_g2 && instr[7] && instr[2]) |=> (acc == $past(switches) && $stable(link)));

  assert_clear_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_g1 && instr[7] && instr[5] && instr[3:0] == 4'b0000) |=> (acc == '1));
endmodule

bind opr_unit opr_unit_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .instr_valid(instr_valid), .instr(instr),
  .switches(switches), .link(link), .acc(acc), .skip(skip), .halt(halt)
);

// File: tb/sim_opr_unit.sv
`timescale 1ns/1ps
module sim_opr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] switches = '0;
  logic        link;
  logic [11:0] acc;
  logic        skip, halt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic        link;
    logic [11:0] acc;
    logic        skip;
    logic        halt;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic        m_link = 1'b0;
  logic [11:0] m_acc = '0;

  always #10 clk = ~clk;

  opr_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .switches(switches), .link(link), .acc(acc), .skip(skip), .halt(halt)
  );

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%o expected=%o", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic v, input logic [11:0] w, input logic [11:0] sw);
    exp_t e;
    logic [12:0] t;
    logic hit;
    e.link = m_link; e.acc = m_acc; e.skip = 0; e.halt = 0;
    if (v && w[11:9] == 3'b111 && !w[8]) begin
      t = {m_link, m_acc};
      if (w[6]) t[12] = 0;
      if (w[7]) t[11:0] = 0;
      if (w[4]) t[12] = ~t[12];
      if (w[5]) t[11:0] = ~t[11:0];
      if (w[0]) t = t + 13'd1;
      case (w[3:1])
        3'b100: t = {t[0], t[12:1]};
        3'b010: t = {t[11:0], t[12]};
        3'b101: t = {t[1:0], t[12:2]};
        3'b011: t = {t[10:0], t[12:11]};
        3'b001: t = {t[12], t[5:0], t[11:6]};
        default: ;
      endcase
      e.link = t[12]; e.acc = t[11:0];
    end else if (v && w[11:9] == 3'b111 && w[8] && !w[0]) begin
      hit = (w[6] && m_acc[11]) || (w[5] && m_acc == 0) || (w[4] && m_link);
      e.skip = w[3] ? !hit : hit;
      e.halt = w[1];
      e.acc = w[7] ? 12'd0 : m_acc;
      if (w[2]) e.acc = e.acc | sw;
    end
    return e;
  endfunction

  task automatic run_op(input logic v, input logic [11:0] w, input logic [11:0] sw, input string tag);
    exp_t e;
    @(negedge clk);
    instr_valid = v; instr = w; switches = sw;
    e = model(v, w, sw);
    e.tag = tag;
    sb.push_back(e);
    m_link = e.link; m_acc = e.acc;
  endtask

  task automatic load(input logic l, input logic [11:0] a);
    run_op(1, 12'o7604, a, "R9 load");
    run_op(1, l ? 12'o7120 : 12'o7100, 12'o0, "R3 link");
  endtask

  // monitor: pulses mid-cycle, state after the edge
  initial begin
    exp_t e;
    logic s, h;
    forever begin
      @(negedge clk); #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        s = skip; h = halt;
        @(posedge clk); #5;
        check({e.tag, " state"}, {link, acc}, {e.link, e.acc});
        check({e.tag, " pulses"}, {11'd0, s, h}, {11'd0, e.skip, e.halt});
      end
    end
  end

  initial begin
    #1;
    @(negedge clk); #5;
    check("R1 reset state", {link, acc}, 13'd0);
    check("R1 reset pulses", {11'd0, skip, halt}, 13'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // group 1 basics
    load(0, 12'o1234);
    run_op(1, 12'o7200, 0, "R3 cla");
    run_op(1, 12'o7040, 0, "R3 cma");
    run_op(1, 12'o7020, 0, "R3 cml");
    run_op(1, 12'o7240, 0, "R3 cla then cma");
    run_op(1, 12'o7120, 0, "R3 cll then cml");
    run_op(1, 12'o7001, 0, "R4 iac wrap");
    load(0, 12'o0005);
    run_op(1, 12'o7041, 0, "R4 negate");
    run_op(1, 12'o7001, 0, "R4 iac plain");
    // rotates
    load(0, 12'o4001); run_op(1, 12'o7010, 0, "R5 ror1");
    load(1, 12'o4001); run_op(1, 12'o7004, 0, "R5 rol1");
    load(0, 12'o4003); run_op(1, 12'o7012, 0, "R5 ror2");
    load(1, 12'o6001); run_op(1, 12'o7006, 0, "R5 rol2");
    load(1, 12'o1234); run_op(1, 12'o7002, 0, "R6 swap");
    load(0, 12'o4321); run_op(1, 12'o7014, 0, "R6 code110");
    run_op(1, 12'o7016, 0, "R6 code111");
    run_op(1, 12'o7011, 0, "R5 iac then ror");
    // group 2
    load(0, 12'o4000);
    run_op(1, 12'o7500, 0, "R7 neg true");
    run_op(1, 12'o7440, 0, "R7 zero false");
    run_op(1, 12'o7420, 0, "R7 link false");
    run_op(1, 12'o7560, 0, "R7 or combo");
    run_op(1, 12'o7510, 0, "R8 pos false");
    run_op(1, 12'o7450, 0, "R8 nonzero true");
    run_op(1, 12'o7430, 0, "R8 link clear true");
    run_op(1, 12'o7410, 0, "R8 unconditional");
    load(1, 12'o0000);
    run_op(1, 12'o7420, 0, "R7 link true");
    run_op(1, 12'o7440, 0, "R7 zero true");
    run_op(1, 12'o7470, 0, "R8 and combo false");
    load(1, 12'o0017);
    run_op(1, 12'o7640, 0, "R9 skip before clear");
    run_op(1, 12'o7404, 12'o5500, "R9 or switches");
    run_op(1, 12'o7644, 12'o0070, "R9 clear then or");
    run_op(1, 12'o7402, 0, "R10 halt");
    run_op(1, 12'o7412, 0, "R10 halt skip");
    run_op(1, 12'o7003, 0, "R10 g1 bit1");
    // no-op words and ignored words
    load(1, 12'o2525);
    run_op(1, 12'o7000, 0, "R11 g1 nop");
    run_op(1, 12'o7400, 0, "R11 g2 nop");
    run_op(1, 12'o1200, 0, "R2 non-operate");
    run_op(1, 12'o6241, 0, "R2 io word");
    run_op(1, 12'o7601, 12'o7777, "R2 group3");
    run_op(0, 12'o7240, 0, "R2 no strobe");
    run_op(0, 12'o7410, 0, "R2 no strobe skip");
    @(negedge clk);
    instr_valid = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule